// File: doc/BRIEF.md
# Envelope-Tracking FSK Bit Slicer

This block turns a stream of signed samples into hard 2FSK bits. Each sample is proportional to the instantaneous frequency of the limited IF signal. A second-order low-pass filter removes excess noise from the samples. A 10-bit bandwidth code sets the filter's coefficient shift.

In parallel, a peak/trough tracker follows the filtered signal. The centre of its span is the decision threshold. Because the threshold moves with the signal, a constant frequency offset between transmitter and receiver does not bias the bit decisions.

The same centre value is driven out as a frequency estimate. An external AFC loop can read it. Clock recovery is done elsewhere: every accepted sample yields one bit.

Top module: `fsk_env_slicer`

## Requirements
- R1: After reset `bit_valid_o`, `bit_o` and `freq_est_o` are all 0.
- R2: `bit_valid_o` pulses high in the cycle after each cycle in which `smp_valid_i` and `en_i` are both high, and is low after every other cycle.
- R3: The filter shift k is the number of leading zeros of `bw_code_i`, counted from bit 9 downward and capped at 6. A code of 0 gives k = 6. Any code with bit 9 set gives k = 0, and then the filtered value equals the input sample exactly.
- R4: The filter is two cascaded one-pole stages updated on each accepted sample, using arithmetic right shifts. The first stage is s1 += (x - s1) >>> k. The second stage is s2 += (s1_new - s2) >>> k. The filtered value is y = s2_new.
- R5: On each accepted sample the tracker first decays each bound toward the other by d = (max - min) >>> 6. It then sets max = larger of (max - d) and y, and min = smaller of (min + d) and y. The centre is (max + min) >>> 1.
- R6: `bit_o` is 1 when y is strictly greater than the updated centre, else 0. It updates together with the `bit_valid_o` pulse.
- R7: `freq_est_o` takes the updated centre together with the `bit_valid_o` pulse. It holds its value while `en_i` stays high and no sample is accepted.
- R8: While `en_i` is low, the filter state, tracker state and `freq_est_o` are cleared to 0 and samples are ignored (no pulse). After re-enable the block behaves as if just out of reset.
- R9: For a square wave of ±400 around a constant offset of ±300 with k = 0, starting from cleared state, every bit equals (sample > offset).
- R10: For full-scale input swings, `freq_est_o` stays within the input sample range (no accumulator wrap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears all state |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 12 | Signed frequency sample |
| bw_code_i | input | 10 | Filter bandwidth code |
| bit_valid_o | output | 1 | Decision strobe |
| bit_o | output | 1 | Sliced data bit |
| freq_est_o | output | 14 | Signed centre-frequency estimate |

## Verification
The bench tests the boundary of the bandwidth code. A one-hot code in bit 9 must pass samples through unfiltered, while a zero code must give the narrowest bandwidth; an off-by-one leading-zero count or a missing cap would make the first bit and estimate after a step differ from the expected values.

Offset square waves above and below zero catch a threshold stuck at zero, a slicer using greater-or-equal, and a tracker whose minimum ignores negative samples. Full-scale alternation exposes accumulators too narrow to hold a difference, which would show up as a wrapped estimate.

Disabling in the middle of a stream checks that samples are dropped and that the state really clears.

// File: rtl/fsk_slicer_pkg.sv
package fsk_slicer_pkg;
  localparam int unsigned BW_CODE_W = 10;

  // leading-zero count of the code, capped at kmax
  function automatic int unsigned bw_to_shift(input logic [BW_CODE_W-1:0] code,
                                              input int unsigned kmax);
    int unsigned lz;
    lz = BW_CODE_W;
    for (int i = 0; i < BW_CODE_W; i++)
      if (code[i]) lz = BW_CODE_W - 1 - i;
    if (lz > kmax) lz = kmax;
    return lz;
  endfunction
endpackage

// File: rtl/fsk_bw_decode.sv
module fsk_bw_decode
  import fsk_slicer_pkg::*;
#(
  parameter int unsigned KMAX = 6,
  parameter int unsigned SH_W = $clog2(KMAX + 1)
) (
  input  logic [BW_CODE_W-1:0] code_i,
  output logic [SH_W-1:0]      shift_o
);
  always_comb shift_o = SH_W'(bw_to_shift(code_i, KMAX));
endmodule

// File: rtl/fsk_lpf2.sv
module fsk_lpf2 #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned ACC_W  = IN_W + 2,
  parameter int unsigned SH_W   = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    load_i,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic signed [ACC_W-1:0] y_o
);
  logic signed [ACC_W-1:0] st_q   [STAGES];
  logic signed [ACC_W-1:0] st_in  [STAGES];
  logic signed [ACC_W-1:0] st_nxt [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic signed [ACC_W:0] diff;
      logic signed [ACC_W:0] step;
      if (g == 0) begin : g_first
        always_comb st_in[g] = ACC_W'(x_i);
      end else begin : g_next
        always_comb st_in[g] = st_nxt[g-1];
      end
      always_comb begin
        diff      = (ACC_W+1)'(st_in[g]) - (ACC_W+1)'(st_q[g]);
        step      = diff >>> shift_i;
        st_nxt[g] = st_q[g] + ACC_W'(step);
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     st_q[g] <= '0;
        else if (!en_i)  st_q[g] <= '0;
        else if (load_i) st_q[g] <= st_nxt[g];
      end
    end
  endgenerate

  assign y_o = st_nxt[STAGES-1];
endmodule

// File: rtl/fsk_env_track.sv
module fsk_env_track #(
  parameter int unsigned ACC_W    = 14,
  parameter int unsigned DECAY_SH = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    load_i,
  input  logic signed [ACC_W-1:0] y_i,
  output logic signed [ACC_W-1:0] centre_o
);
  localparam int unsigned EW = ACC_W + 1;

  logic signed [ACC_W-1:0] hi_q, lo_q;
  logic signed [EW-1:0]    span, dec, hi_d, lo_d, hi_n, lo_n, sum;

  always_comb begin
    span = EW'(hi_q) - EW'(lo_q);
    dec  = span >>> DECAY_SH;
    hi_d = EW'(hi_q) - dec;
    lo_d = EW'(lo_q) + dec;
    hi_n = (EW'(y_i) > hi_d) ? EW'(y_i) : hi_d;
    lo_n = (EW'(y_i) < lo_d) ? EW'(y_i) : lo_d;
    sum  = hi_n + lo_n;
    centre_o = ACC_W'(sum >>> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (!en_i) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= ACC_W'(hi_n);
      lo_q <= ACC_W'(lo_n);
    end
  end
endmodule

// File: rtl/fsk_env_slicer.sv
module fsk_env_slicer
  import fsk_slicer_pkg::*;
#(
  parameter int unsigned SMP_W    = 12,
  parameter int unsigned KMAX     = 6,
  parameter int unsigned DECAY_SH = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      smp_valid_i,
  input  logic [SMP_W-1:0]          smp_i,
  input  logic [BW_CODE_W-1:0]      bw_code_i,
  output logic                      bit_valid_o,
  output logic                      bit_o,
  output logic [SMP_W+1:0]          freq_est_o
);
  localparam int unsigned ACC_W = SMP_W + 2;
  localparam int unsigned SH_W  = $clog2(KMAX + 1);

  logic                    load;
  logic [SH_W-1:0]         shift;
  logic signed [ACC_W-1:0] y_w, centre_w;
  logic                    vld_q, bit_q;
  logic signed [ACC_W-1:0] est_q;

  assign load = smp_valid_i & en_i;

  fsk_bw_decode #(.KMAX(KMAX), .SH_W(SH_W)) u_bw (
    .code_i (bw_code_i),
    .shift_o(shift)
  );

  fsk_lpf2 #(.IN_W(SMP_W), .ACC_W(ACC_W), .SH_W(SH_W), .STAGES(2)) u_lpf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .load_i (load),
    .x_i    ($signed(smp_i)),
    .shift_i(shift),
    .y_o    (y_w)
  );

  fsk_env_track #(.ACC_W(ACC_W), .DECAY_SH(DECAY_SH)) u_env (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (load),
    .y_i     (y_w),
    .centre_o(centre_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
      est_q <= '0;
    end else begin
      vld_q <= load;
      if (!en_i) begin
        est_q <= '0;
      end else if (load) begin
        bit_q <= (y_w > centre_w);
        est_q <= centre_w;
      end
    end
  end

  assign bit_valid_o = vld_q;
  assign bit_o       = bit_q;
  assign freq_est_o  = est_q;
endmodule

// File: rtl/fsk_env_slicer_chk.sv
module fsk_env_slicer_chk #(
  parameter int unsigned SMP_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             smp_valid_i,
  input logic             bit_valid_o,
  input logic [SMP_W+1:0] freq_est_o
);
  localparam int EST_MAX = 2 ** (SMP_W - 1) - 1;
  localparam int EST_MIN = -(2 ** (SMP_W - 1));

  AST_STROBE_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && en_i) |=> bit_valid_o); // R2
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_valid_i && en_i) |=> !bit_valid_o); // R2
  AST_EST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !bit_valid_o) |-> $stable(freq_est_o)); // R7
  AST_DISABLED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (freq_est_o == '0 && !bit_valid_o)); // R8
  AST_EST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(freq_est_o) <= EST_MAX && $signed(freq_est_o) >= EST_MIN)); // R10
endmodule

bind fsk_env_slicer fsk_env_slicer_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .smp_valid_i(smp_valid_i),
  .bit_valid_o(bit_valid_o),
  .freq_est_o (freq_est_o)
);

// File: tb/fsk_env_slicer_tb.sv
module fsk_env_slicer_tb;
  localparam int W = 12;
  localparam int NV = 24;

  localparam logic [9:0] TV_CODE [NV] = '{
    10'h3ff, 10'h3ff, 10'h3ff, 10'h100, 10'h100, 10'h100,
    10'h080, 10'h080, 10'h080, 10'h040, 10'h040, 10'h040,
    10'h020, 10'h020, 10'h001, 10'h001, 10'h000, 10'h000,
    10'h200, 10'h200, 10'h010, 10'h010, 10'h0ff, 10'h0ff};
  localparam int TV_X [NV] = '{
    500, -500, 500, 900, -300, 900,
    -1200, 40, -1200, 1800, 1800, -1800,
    0, 700, -700, 700, 2047, -2048,
    -100, 100, 333, -333, 1500, -1500};

  logic clk = 0, rst_ni = 0, en = 0, vld = 0;
  logic [W-1:0] smp = '0;
  logic [9:0] code = '0;
  logic bit_valid, bit_q;
  logic [W+1:0] est;

  int tests = 0, fails = 0;
  int m_s1, m_s2, m_hi, m_lo, e_bit, e_c;

  always #10 clk = ~clk;

  fsk_env_slicer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .smp_valid_i(vld), .smp_i(smp),
    .bw_code_i(code), .bit_valid_o(bit_valid), .bit_o(bit_q), .freq_est_o(est));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int shift_of(input logic [9:0] c);
    int k = 6;
    for (int i = 9; i >= 0; i--)
      if (c[i]) begin k = 9 - i; break; end
    return (k > 6) ? 6 : k;
  endfunction

  task automatic model_clear();
    m_s1 = 0; m_s2 = 0; m_hi = 0; m_lo = 0;
  endtask

  task automatic model_step(input int x, input logic [9:0] c);
    int k, y, d, hd, ld;
    k = shift_of(c);
    m_s1 = m_s1 + ((x - m_s1) >>> k);
    m_s2 = m_s2 + ((m_s1 - m_s2) >>> k);
    y = m_s2;
    d = (m_hi - m_lo) >>> 6;
    hd = m_hi - d; ld = m_lo + d;
    m_hi = (y > hd) ? y : hd;
    m_lo = (y < ld) ? y : ld;
    e_c = (m_hi + m_lo) >>> 1;
    e_bit = (y > e_c) ? 1 : 0;
  endtask

  // drive one accepted sample, return at the negedge after capture
  task automatic send(input int x, input logic [9:0] c);
    @(negedge clk);
    vld = 1; smp = W'(x); code = c;
    @(negedge clk);
    vld = 0;
    model_step(x, c);
  endtask

  task automatic clear_dut();
    @(negedge clk); en = 0;
    @(negedge clk); en = 1;
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 bit_valid", int'(bit_valid), 0);
    chk("R1 bit", int'(bit_q), 0);
    chk("R1 est", int'($signed(est)), 0);
    rst_ni = 1;
    @(negedge clk); en = 1;

    // R3: passthrough code gives y=x=200 -> centre 100, bit 1
    send(200, 10'h200);
    chk("R2 strobe", int'(bit_valid), 1);
    chk("R3 pass est", int'($signed(est)), 100);
    chk("R3 pass bit", int'(bit_q), 1);
    @(negedge clk);
    chk("R2 no strobe", int'(bit_valid), 0);
    chk("R7 hold", int'($signed(est)), 100);

    // R3: code 0 -> k=6, y=0 -> centre 0, bit 0
    clear_dut();
    send(200, 10'h000);
    chk("R3 narrow est", int'($signed(est)), 0);
    chk("R3 narrow bit", int'(bit_q), 0);

    // R8: samples dropped while disabled, state fresh afterwards
    send(-900, 10'h200);
    @(negedge clk); en = 0; vld = 1; smp = W'(1000); code = 10'h200;
    @(negedge clk); vld = 0;
    chk("R8 no strobe", int'(bit_valid), 0);
    chk("R8 est cleared", int'($signed(est)), 0);
    @(negedge clk); en = 1;
    model_clear();
    send(200, 10'h200);
    chk("R8 fresh est", int'($signed(est)), 100);

    // R4 R5 R6 R7: table walk against model
    clear_dut();
    for (int i = 0; i < NV; i++) begin
      send(TV_X[i], TV_CODE[i]);
      chk("R4/R6 bit", int'(bit_q), e_bit);
      chk("R5/R7 est", int'($signed(est)), e_c);
    end

    // R9: offset square waves, threshold follows offset
    for (int o = 0; o < 2; o++) begin
      int off = (o == 0) ? 300 : -300;
      clear_dut();
      for (int i = 0; i < 40; i++) begin
        int x = off + ((i % 2 == 0) ? 400 : -400);
        send(x, 10'h3ff);
        chk("R9 offset bit", int'(bit_q), (x > off) ? 1 : 0);
      end
    end

    // R10: full-scale swings through filter
    clear_dut();
    for (int i = 0; i < 30; i++) begin
      int x = (i % 2 == 0) ? 2047 : -2048;
      send(x, (i < 15) ? 10'h200 : 10'h100);
      chk("R10 est", int'($signed(est)), e_c);
      chk("R10 range", int'($signed(est) <= 2047 && $signed(est) >= -2048), 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule